// File: doc/BRIEF.md
# Latched Maskable Interrupt Controller

This block gathers a vector of already-qualified event pulses and turns them into one active-high interrupt request for a host processor. Each source has a sticky status bit, which is set by its event and held until software clears it, and a mask bit that decides whether that pending status may drive the request line. A third view, the sense word, shows the live source levels as they are now. That view is not latched and cannot be written.

The host reaches the block through a small register port with a write strobe, a read strobe, an address and data. The host reads the status, mask and sense words. It clears status bits by writing ones and sets the mask with a full-word write. After reset every source is masked except one designated source, so the host either polls the status word or unmasks the sources it wants. The request line comes from a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` when any unmasked status bit will be set after the current edge. `IRQ_RAISED` moves back to `IRQ_QUIET` when none will remain. Every other case holds the current state.

Register addresses: 0 = status, 1 = mask, 2 = sense, and any other address is unimplemented.

Top module: `irq_latch_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when at least one status bit is 1 and its mask bit is 0.
- R2: An event pulse on a source sets its status bit. The bit stays 1 after the pulse ends, until software clears it.
- R3: A write to address 0 clears every status bit whose `wr_data` bit is 1 and leaves the bits written 0 unchanged. Once no unmasked status bit remains, `irq_o` returns to 0.
- R4: When an event arrives in the same cycle as a status clear, the line stays 1 if the event's source is unmasked. If the event hits the bit being cleared, the bit ends up set.
- R5: A source whose mask bit is 1 still sets its status bit, and that bit reads back at address 0, but the source does not raise `irq_o`.
- R6: After reset every mask bit reads 1 except bit `BOOT_IDX`, which reads 0. All status bits read 0 and `irq_o` is 0.
- R7: Writing 0 to the mask bit of a source whose status bit is already 1 raises `irq_o` without any new event.
- R8: A read of address 2 returns the current `src_level` in bits [NUM_SRC-1:0]. The value follows the inputs without latching, and writes to address 2 change neither status nor mask.
- R9: A read of an unimplemented address returns 0, and writes there have no effect. Data bits at and above NUM_SRC always read 0, and a write to address 1 stores only bits [NUM_SRC-1:0] as the mask.
- R10: `irq_o` is registered. It changes at the clock edge that captures the event or write that caused the change, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | NUM_SRC | Qualified event pulses, one per source |
| src_level | input | NUM_SRC | Live source levels for the sense word |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid while `rd_en` is 1, otherwise 0 |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with NUM_SRC = 6, DATA_W = 8 and BOOT_IDX = 4. With these values the designated unmasked source is not bit 0, so a reset mask of 0x2F can only come from the parameter and not from a hard-wired position. The data word is wider than the source count, which makes the read-as-zero upper bits and the truncated mask write observable. The six-bit vectors allow an event and a clear on different bits, or on the same bit, within a single cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_SENSE  = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/intc_status_bank.sv
module intc_status_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_pulse,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] status_nxt
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // a set on the same cycle as a clear wins
        assign status_nxt[i] = ev_pulse[i] | (status_q[i] & ~clr_vec[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q[i] <= 1'b0;
            else        status_q[i] <= status_nxt[i];
        end
    end

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
    parameter int NUM_SRC  = 8,
    parameter int BOOT_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_SRC-1:0] load_bits,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] mask_nxt
);

    localparam logic [NUM_SRC-1:0] RST_MASK = ~(NUM_SRC'(1) << BOOT_IDX);

    assign mask_nxt = load ? load_bits : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= RST_MASK;
        else        mask_q <= mask_nxt;
    end

endmodule

// File: rtl/intc_irq_fsm.sv
module intc_irq_fsm
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nxt,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_nxt)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_nxt) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    assign irq_o = (state_q == IRQ_RAISED);

endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import irq_latch_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 16
) (
    input  logic               rd_en,
    input  reg_sel_e           sel,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] sense,
    output logic [DATA_W-1:0]  rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                REG_STATUS: rd_data = DATA_W'(status_q);
                REG_MASK:   rd_data = DATA_W'(mask_q);
                REG_SENSE:  rd_data = DATA_W'(sense);
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 2,
    parameter int BOOT_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_pulse,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] status_q, status_nxt;
    logic [NUM_SRC-1:0] mask_q, mask_nxt;
    logic               mask_load;
    logic               pend_nxt;
    logic               unused_wr_hi;

    assign sel = ((addr >> 2) == '0) ? reg_sel_e'(addr[1:0]) : REG_NONE;

    assign clr_vec      = (wr_en && sel == REG_STATUS) ? wr_data[NUM_SRC-1:0] : '0;
    assign mask_load    = wr_en && (sel == REG_MASK);
    assign unused_wr_hi = ^wr_data;

    intc_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_pulse   (ev_pulse),
        .clr_vec    (clr_vec),
        .status_q   (status_q),
        .status_nxt (status_nxt)
    );

    intc_mask_bank #(.NUM_SRC(NUM_SRC), .BOOT_IDX(BOOT_IDX)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mask_load),
        .load_bits (wr_data[NUM_SRC-1:0]),
        .mask_q    (mask_q),
        .mask_nxt  (mask_nxt)
    );

    assign pend_nxt = |(status_nxt & ~mask_nxt);

    intc_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_nxt (pend_nxt),
        .irq_o    (irq_o)
    );

    intc_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .rd_en    (rd_en),
        .sel      (sel),
        .status_q (status_q),
        .mask_q   (mask_q),
        .sense    (src_level),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
    parameter int NUM_SRC  = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 2,
    parameter int BOOT_IDX = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ev_pulse,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  rd_data,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q
);

    localparam logic [NUM_SRC-1:0] RST_MASK = ~(NUM_SRC'(1) << BOOT_IDX);

    logic wr_status, wr_sense, rd_none;
    assign wr_status = wr_en && (addr == ADDR_W'(0));
    assign wr_sense  = wr_en && (addr == ADDR_W'(2));
    assign rd_none   = rd_en && (addr >= ADDR_W'(3));

    // R1
    irq_matches_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_q & ~mask_q));

    // R2
    event_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |ev_pulse |=> ((status_q & $past(ev_pulse)) == $past(ev_pulse)));

    // R4
    clear_collision_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && wr_status && |(ev_pulse & ~mask_q)) |=> irq_o);

    // R6
    reset_mask_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_q == RST_MASK && status_q == '0 && !irq_o));

    // R8
    sense_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sense && ev_pulse == '0) |=> ($stable(mask_q) && $stable(status_q)));

    // R9
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_none |-> rd_data == '0);

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BOOT_IDX(BOOT_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_pulse (ev_pulse),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rd_data  (rd_data),
    .irq_o    (irq_o),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/irq_latch_ctrl_tb.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb;

    localparam int N    = 6;
    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam int BOOT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_pulse = '0;
    logic [N-1:0]  src_level = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          irq_o;

    always #10 clk = ~clk;

    irq_latch_ctrl #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW), .BOOT_IDX(BOOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .src_level(src_level),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_status = '0;
    logic [N-1:0] m_mask   = ~(N'(1) << BOOT);

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops the scoreboard for every read strobe
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) check("read-unexpected", rd_data, '0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    function automatic logic m_irq();
        return |(m_status & ~m_mask);
    endfunction

    // one bus/event cycle; model is updated at the edge that captures it
    task automatic cyc(input logic [N-1:0] ev, input logic wen, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        logic [N-1:0] clr;
        @(posedge clk); #2;
        ev_pulse = ev; wr_en = wen; addr = a; wr_data = d;
        @(posedge clk); #2;
        clr = (wen && a == 2'd0) ? d[N-1:0] : '0;
        if (wen && a == 2'd1) m_mask = d[N-1:0];
        m_status = ev | (m_status & ~clr);
        ev_pulse = '0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(posedge clk); #2;
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #2;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        check("R6 irq after reset", DW'(irq_o), 0);
        rd(2'd1, 8'h2F, "R6 reset mask");
        rd(2'd0, 8'h00, "R6 reset status");

        cyc(6'h01, 0, 0, 0);
        check("R5 masked event no irq", DW'(irq_o), 0);
        rd(2'd0, 8'h01, "R5 masked status readable");
        repeat (3) @(posedge clk);
        rd(2'd0, 8'h01, "R2 status sticky");

        cyc('0, 1, 2'd1, 8'h2E);
        check("R7 unmask pending raises irq", DW'(irq_o), DW'(m_irq()));
        cyc('0, 1, 2'd0, 8'h00);
        check("R3 write zero keeps irq", DW'(irq_o), 1);
        rd(2'd0, 8'h01, "R3 write zero keeps status");
        cyc('0, 1, 2'd0, 8'h01);
        check("R3 clear drops irq", DW'(irq_o), 0);

        cyc(6'h10, 0, 0, 0);
        check("R1 boot source raises irq", DW'(irq_o), 1);
        cyc(6'h01, 1, 2'd0, 8'h10);
        check("R4 clear with other event keeps irq", DW'(irq_o), DW'(m_irq()));
        rd(2'd0, DW'(m_status), "R4 status after collision");
        cyc(6'h01, 1, 2'd0, 8'h01);
        rd(2'd0, 8'h01, "R4 same-bit set beats clear");
        cyc('0, 1, 2'd0, 8'h01);
        check("R3 all cleared irq low", DW'(irq_o), 0);

        src_level = 6'h2A;
        rd(2'd2, 8'h2A, "R8 sense level");
        src_level = 6'h15;
        rd(2'd2, 8'h15, "R8 sense follows input");
        cyc('0, 1, 2'd2, 8'hFF);
        rd(2'd0, 8'h00, "R8 sense write leaves status");
        rd(2'd1, 8'h2E, "R8 sense write leaves mask");

        rd(2'd3, 8'h00, "R9 unimplemented read zero");
        cyc('0, 1, 2'd3, 8'hFF);
        rd(2'd1, 8'h2E, "R9 unimplemented write ignored");
        cyc('0, 1, 2'd1, 8'hFF);
        rd(2'd1, 8'h3F, "R9 upper data bits read zero");

        cyc('0, 1, 2'd1, 8'h3E);
        @(posedge clk); #2;
        ev_pulse = 6'h01;
        #5;
        check("R10 irq not before edge", DW'(irq_o), 0);
        @(posedge clk); #2;
        ev_pulse = '0;
        m_status = m_status | 6'h01;
        check("R10 irq at capturing edge", DW'(irq_o), DW'(m_irq()));

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) check("read queue drained", DW'(exp_q.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule